// File: doc/BRIEF.md
# Compare-Increment-Branch Execute Unit

This block is the execute-stage datapath for a single custom I-type instruction that folds three actions into one: it tests whether one register is below another, branches relative to the program counter when it is, and writes that same register back incremented by one. It receives the instruction word, the two register-file read values and the address of the next sequential instruction. It produces a branch decision, the branch target address and one register-file write request.

The condition is judged on the register's value before the increment. The write-back happens whether or not the branch is taken. While a matching instruction sits at the input, the block asks the fetch logic to hold, because the branch outcome is not yet known.

All results except the stall request pass through one bank of flops, which stands in for the pipeline register into the following stage. Only one adder is added beyond the compare subtractor and the target adder, and it is used for the increment.

Top module: `cib_exec_unit`

## Requirements
- R1: The instruction word uses opcode at bits 31-26, source field at bits 25-21, destination/compare field at bits 20-16 and a 16-bit immediate at bits 15-0. `fetch_stall` is high in the same cycle as, and only when, `in_valid` is 1 and bits 31-26 equal the parameter `OPCODE` (default 6'h3A).
- R2: On a cycle where `in_valid` is 0 or the opcode does not match, `fetch_stall` is 0, and after the next rising edge `br_taken`, `wb_en`, `br_target`, `wb_data` and `wb_dest` are all zero.
- R3: For an issued instruction, `br_taken` is 1 exactly when `rt_val` is less than `rs_val` as signed 32-bit two's-complement numbers. The order is rt-below-rs, not the reverse.
- R4: The comparison uses `rt_val` as read, never the incremented value. For example, rt = rs - 1 is taken even though rt + 1 equals rs.
- R5: For an issued instruction, `wb_data` equals `rt_val + 1` modulo 2^32 whether taken or not. 0xFFFFFFFF becomes 0x00000000 and 0x7FFFFFFF becomes 0x80000000, with no trap.
- R6: For an issued instruction, `wb_en` is 1 and `wb_dest` equals bits 20-16 of the instruction. This is the only write per instruction.
- R7: For an issued instruction, `br_target` equals `pc_plus4` plus the sign-extended immediate shifted left by two, modulo 2^32. It is valid for both positive and negative immediates and is produced even when the branch is not taken.
- R8: `br_taken`, `br_target`, `wb_data`, `wb_dest` and `wb_en` change only at a rising edge and reflect the instruction presented in the cycle before that edge. A low `rst_n` at a rising edge clears them all to zero. A taken branch is always accompanied by `wb_en`.
- R9: When `rt_val` equals `rs_val`, the branch is not taken, and the register is still written with the value plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word on `instr` is live this cycle |
| instr | input | 32 | I-type instruction word |
| rs_val | input | 32 | Register-file value read from the bits 25-21 field |
| rt_val | input | 32 | Register-file value read from the bits 20-16 field |
| pc_plus4 | input | 32 | Address of the next sequential instruction |
| br_taken | output | 1 | Registered branch decision |
| br_target | output | 32 | Registered branch target address |
| wb_data | output | 32 | Registered write-back value (old rt plus one) |
| wb_dest | output | 5 | Registered write-back register index |
| wb_en | output | 1 | Registered register-file write request |
| fetch_stall | output | 1 | Combinational request to hold fetch while the instruction resolves |

## Verification
The block holds state only in its output flops, so any corruption appears at the ports one edge after the instruction that caused it, and the next instruction overwrites it. A swapped compare order or an unsigned compare shows only for operand pairs whose order or signs disagree. A compare taken after the increment shows only when rt sits one below rs. Because of this, the stimulus deliberately targets the sign boundary, equality, the value just below rs, and both signs of the immediate. A load enable stuck in the wrong state shows as a nonzero output after an idle or foreign-opcode cycle, or as a missing write after an issued one.

// File: rtl/cib_pkg.sv
// Package: shared constants and the decode result type for the
// compare-increment-branch execute unit.
// Assumes the fixed I-type layout: opcode, source, destination, immediate
// from the most significant end down.
package cib_pkg;

    localparam int DEF_DATA_W    = 32;
    localparam int DEF_REG_IDX_W = 5;
    localparam int DEF_OPC_W     = 6;
    localparam int DEF_IMM_W     = 16;

    // Kind of work the decoder hands to the output stage.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_CIB  = 1'b1
    } slot_kind_e;

endpackage

// File: rtl/cib_decode.sv
// Module: cib_decode
// Splits the instruction word into its fields and flags whether this cycle
// carries a live compare-increment-branch instruction.
// Assumes the opcode sits at the top, then source, then destination, then
// the immediate at the bottom.
module cib_decode
    import cib_pkg::*;
#(
    parameter int                 REG_IDX_W = DEF_REG_IDX_W,
    parameter int                 OPC_W     = DEF_OPC_W,
    parameter int                 IMM_W     = DEF_IMM_W,
    parameter logic [OPC_W-1:0]   OPCODE    = 6'h3A
) (
    input  logic                              in_valid,
    input  logic [OPC_W+2*REG_IDX_W+IMM_W-1:0] instr,
    output slot_kind_e                        kind,
    output logic [REG_IDX_W-1:0]              dst_idx,
    output logic [IMM_W-1:0]                  imm
);

    localparam int INSTR_W = OPC_W + 2*REG_IDX_W + IMM_W;
    localparam int DST_LO  = IMM_W;
    localparam int SRC_LO  = IMM_W + REG_IDX_W;
    localparam int OPC_LO  = IMM_W + 2*REG_IDX_W;

    logic [OPC_W-1:0]     opc_field;
    logic [REG_IDX_W-1:0] unused_src_field;

    // Field extraction by fixed layout position.
    always_comb begin
        opc_field        = instr[INSTR_W-1:OPC_LO];
        unused_src_field = instr[SRC_LO+REG_IDX_W-1:SRC_LO];
        dst_idx          = instr[DST_LO+REG_IDX_W-1:DST_LO];
        imm              = instr[IMM_W-1:0];
    end

    // Issue qualification: valid strobe and exact opcode match.
    always_comb begin
        kind = (in_valid && (opc_field == OPCODE)) ? SLOT_CIB : SLOT_IDLE;
    end

endmodule

// File: rtl/cib_compare.sv
// Module: cib_compare
// Signed less-than test a < b built on a single subtraction with overflow
// correction, as the existing ALU would do it.
// Assumes two's-complement operands of equal width.
module cib_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt
);

    logic [W-1:0] diff;
    logic         ovf;

    // Subtract, detect signed overflow, correct the sign bit.
    always_comb begin
        diff = a - b;
        ovf  = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
        lt   = diff[W-1] ^ ovf;
    end

endmodule

// File: rtl/cib_target.sv
// Module: cib_target
// PC-relative branch target: next sequential address plus the
// sign-extended word offset.
// Assumes word-aligned instructions, so the offset is shifted by two.
module cib_target #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     pc_next,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     target
);

    localparam int EXT_W = W - IMM_W - 2;

    logic [W-1:0] byte_off;

    // Sign-extend and scale the immediate, then add.
    always_comb begin
        byte_off = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target   = pc_next + byte_off;
    end

endmodule

// File: rtl/cib_incr.sv
// Module: cib_incr
// The one added adder: old destination value plus one, wrapping.
// Assumes no overflow trap is wanted.
module cib_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] val_p1
);

    localparam logic [W-1:0] ONE = W'(1);

    // Modulo-2^W increment.
    always_comb begin
        val_p1 = val + ONE;
    end

endmodule

// File: rtl/cib_stage_reg.sv
// Module: cib_stage_reg
// Output flops standing in for the pipeline register into the next stage.
// Loads results for an issued instruction, otherwise loads zeros.
// Assumes synchronous active-low reset.
module cib_stage_reg
    import cib_pkg::*;
#(
    parameter int W         = 32,
    parameter int REG_IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_kind_e           kind,
    input  logic                 taken_d,
    input  logic [W-1:0]         target_d,
    input  logic [W-1:0]         data_d,
    input  logic [REG_IDX_W-1:0] dest_d,
    output logic                 taken_q,
    output logic [W-1:0]         target_q,
    output logic [W-1:0]         data_q,
    output logic [REG_IDX_W-1:0] dest_q,
    output logic                 wen_q
);

    // Capture results of an issued instruction; clear on reset or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || kind != SLOT_CIB) begin
            taken_q  <= 1'b0;
            target_q <= '0;
            data_q   <= '0;
            dest_q   <= '0;
            wen_q    <= 1'b0;
        end else begin
            taken_q  <= taken_d;
            target_q <= target_d;
            data_q   <= data_d;
            dest_q   <= dest_d;
            wen_q    <= 1'b1;
        end
    end

endmodule

// File: rtl/cib_exec_unit.sv
// Module: cib_exec_unit (top)
// Execute stage for compare-increment-branch: branch when rt < rs (signed,
// old rt value), write rt+1 back to rt in every case, stall fetch while the
// instruction is being resolved.
// Assumes register reads are already done and hazards are handled outside.
module cib_exec_unit
    import cib_pkg::*;
#(
    parameter int               DATA_W    = DEF_DATA_W,
    parameter int               REG_IDX_W = DEF_REG_IDX_W,
    parameter int               OPC_W     = DEF_OPC_W,
    parameter int               IMM_W     = DEF_IMM_W,
    parameter logic [OPC_W-1:0] OPCODE    = 6'h3A
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [OPC_W+2*REG_IDX_W+IMM_W-1:0] instr,
    input  logic [DATA_W-1:0]                  rs_val,
    input  logic [DATA_W-1:0]                  rt_val,
    input  logic [DATA_W-1:0]                  pc_plus4,
    output logic                               br_taken,
    output logic [DATA_W-1:0]                  br_target,
    output logic [DATA_W-1:0]                  wb_data,
    output logic [REG_IDX_W-1:0]               wb_dest,
    output logic                               wb_en,
    output logic                               fetch_stall
);

    slot_kind_e           kind;
    logic [REG_IDX_W-1:0] dst_idx;
    logic [IMM_W-1:0]     imm;
    logic                 rt_below_rs;
    logic [DATA_W-1:0]    target_c;
    logic [DATA_W-1:0]    rt_inc;

    cib_decode #(
        .REG_IDX_W (REG_IDX_W),
        .OPC_W     (OPC_W),
        .IMM_W     (IMM_W),
        .OPCODE    (OPCODE)
    ) u_decode (
        .in_valid (in_valid),
        .instr    (instr),
        .kind     (kind),
        .dst_idx  (dst_idx),
        .imm      (imm)
    );

    // Operand order matters: the destination register is the left operand.
    cib_compare #(.W(DATA_W)) u_compare (
        .a  (rt_val),
        .b  (rs_val),
        .lt (rt_below_rs)
    );

    cib_target #(.W(DATA_W), .IMM_W(IMM_W)) u_target (
        .pc_next (pc_plus4),
        .imm     (imm),
        .target  (target_c)
    );

    cib_incr #(.W(DATA_W)) u_incr (
        .val    (rt_val),
        .val_p1 (rt_inc)
    );

    cib_stage_reg #(.W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .taken_d  (rt_below_rs),
        .target_d (target_c),
        .data_d   (rt_inc),
        .dest_d   (dst_idx),
        .taken_q  (br_taken),
        .target_q (br_target),
        .data_q   (wb_data),
        .dest_q   (wb_dest),
        .wen_q    (wb_en)
    );

    // Hold fetch for the cycle the branch outcome is being resolved.
    always_comb begin
        fetch_stall = (kind == SLOT_CIB);
    end

endmodule

// File: rtl/cib_exec_checker.sv
// Module: cib_exec_checker
// Port-level properties of the execute unit, attached by bind.
module cib_exec_checker #(
    parameter int               DATA_W    = 32,
    parameter int               REG_IDX_W = 5,
    parameter int               OPC_W     = 6,
    parameter int               IMM_W     = 16,
    parameter logic [OPC_W-1:0] OPCODE    = 6'h3A
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               in_valid,
    input logic [OPC_W+2*REG_IDX_W+IMM_W-1:0] instr,
    input logic [DATA_W-1:0]                  rs_val,
    input logic [DATA_W-1:0]                  rt_val,
    input logic [DATA_W-1:0]                  pc_plus4,
    input logic                               br_taken,
    input logic [DATA_W-1:0]                  br_target,
    input logic [DATA_W-1:0]                  wb_data,
    input logic [REG_IDX_W-1:0]               wb_dest,
    input logic                               wb_en,
    input logic                               fetch_stall
);

    localparam int INSTR_W = OPC_W + 2*REG_IDX_W + IMM_W;
    localparam int EXT_W   = DATA_W - IMM_W - 2;

    // R1
    stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (in_valid && instr[INSTR_W-1:INSTR_W-OPC_W] == OPCODE));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stall |=> (!wb_en && !br_taken && wb_data == '0 && br_target == '0));

    // R3 (R4: old rt value is the left operand)
    cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (br_taken == ($signed($past(rt_val)) < $signed($past(rs_val)))));

    // R5
    incr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (wb_data == DATA_W'($past(rt_val) + DATA_W'(1))));

    // R6
    dest_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (wb_en && wb_dest == $past(instr[IMM_W+REG_IDX_W-1:IMM_W])));

    // R7
    target_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (br_target == DATA_W'($past(pc_plus4) +
            {{EXT_W{$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0]), 2'b00})));

    // R8
    taken_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> wb_en);

endmodule

bind cib_exec_unit cib_exec_checker #(
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .OPC_W     (OPC_W),
    .IMM_W     (IMM_W),
    .OPCODE    (OPCODE)
) u_cib_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .pc_plus4    (pc_plus4),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .wb_data     (wb_data),
    .wb_dest     (wb_dest),
    .wb_en       (wb_en),
    .fetch_stall (fetch_stall)
);

// File: tb/cib_exec_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for cib_exec_unit: the driver pushes expected results,
// the monitor pops and compares one edge later.
module cib_exec_unit_bench;

    localparam logic [5:0] OPC = 6'h3A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc_plus4 = '0;
    logic        br_taken;
    logic [31:0] br_target;
    logic [31:0] wb_data;
    logic [4:0]  wb_dest;
    logic        wb_en;
    logic        fetch_stall;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic        taken;
        logic [31:0] target;
        logic [31:0] data;
        logic [4:0]  dest;
        logic        en;
        string       req;
    } exp_t;

    exp_t sb[$];

    cib_exec_unit #(.OPCODE(OPC)) u_cib_exec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .instr       (instr),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .pc_plus4    (pc_plus4),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .wb_data     (wb_data),
        .wb_dest     (wb_dest),
        .wb_en       (wb_en),
        .fetch_stall (fetch_stall)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [70:0] act, input logic [70:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: present one cycle of stimulus, check the stall, push expectation.
    task automatic drive(input logic v, input logic [5:0] opc, input logic [4:0] rs_i,
                         input logic [4:0] rt_i, input logic [15:0] imm,
                         input logic [31:0] rsv, input logic [31:0] rtv,
                         input logic [31:0] pc, input string req);
        exp_t e;
        logic issue;
        @(negedge clk);
        in_valid = v;
        instr    = {opc, rs_i, rt_i, imm};
        rs_val   = rsv;
        rt_val   = rtv;
        pc_plus4 = pc;
        issue    = v && (opc == OPC);
        #1;
        check(fetch_stall == issue, {"R1 ", req}, "fetch_stall",
              71'(fetch_stall), 71'(issue));
        if (issue) begin
            e.taken  = $signed(rtv) < $signed(rsv);
            e.target = pc + {{14{imm[15]}}, imm, 2'b00};
            e.data   = rtv + 32'd1;
            e.dest   = rt_i;
            e.en     = 1'b1;
        end else begin
            e.taken = 1'b0; e.target = '0; e.data = '0; e.dest = '0; e.en = 1'b0;
        end
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare registered outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({br_taken, br_target, wb_data, wb_dest, wb_en} ==
                  {e.taken, e.target, e.data, e.dest, e.en}, e.req,
                  "{taken,target,data,dest,en}",
                  {br_taken, br_target, wb_data, wb_dest, wb_en},
                  {e.taken, e.target, e.data, e.dest, e.en});
        end
    end

    initial begin
        #(20.0 * 200000);
        fails++;
        $display("FAIL R8 watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check({br_taken, br_target, wb_data, wb_dest, wb_en} == '0, "R8", "reset outputs",
              {br_taken, br_target, wb_data, wb_dest, wb_en}, '0);
        rst_n = 1'b1;

        drive(1, OPC, 5'd20, 5'd19, 16'h0010, 32'd10, 32'd5, 32'h1000, "R3 taken rt<rs");
        drive(1, OPC, 5'd2,  5'd3,  16'h0004, 32'd5,  32'd10, 32'h2000, "R3 not taken rt>rs R5");
        drive(1, OPC, 5'd4,  5'd7,  16'h0001, 32'd42, 32'd42, 32'h3000, "R9 equal not taken");
        drive(1, OPC, 5'd8,  5'd9,  16'h0002, 32'd10, 32'd9,  32'h4000, "R4 old value rt=rs-1");
        drive(1, OPC, 5'd1,  5'd31, 16'h0000, 32'd1,  32'hFFFF_FFFF, 32'h5000, "R5 wrap to zero R3 signed");
        drive(1, OPC, 5'd5,  5'd6,  16'h0008, 32'h8000_0000, 32'h7FFF_FFFF, 32'h6000, "R5 0x7FFFFFFF R3 signed");
        drive(1, OPC, 5'd10, 5'd11, 16'hFFFC, 32'd3,  32'd1,  32'h7000, "R7 negative offset");
        drive(1, OPC, 5'd12, 5'd0,  16'h7FFF, 32'd0,  32'd0,  32'h0000_0100, "R7 max positive offset R6 dest 0");
        drive(1, 6'h04, 5'd1, 5'd2, 16'h0010, 32'd10, 32'd5,  32'h8000, "R2 foreign opcode");
        drive(0, OPC, 5'd1,  5'd2,  16'h0010, 32'd10, 32'd5,  32'h9000, "R2 valid low");
        drive(1, OPC, 5'd13, 5'd14, 16'h0020, 32'hFFFF_FFF0, 32'hFFFF_FFFE, 32'hA000, "R3 both negative R8 back-to-back");
        drive(1, OPC, 5'd15, 5'd16, 16'h0030, 32'd100, 32'h8000_0000, 32'hB000, "R6 R8 back-to-back");
        drive(0, 6'h00, 5'd0, 5'd0, 16'h0000, 32'd0, 32'd0, 32'd0, "R2 idle after issue");

        // R8: mid-run reset overrides an issued instruction
        wait (sb.size() == 0);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = {OPC, 5'd1, 5'd2, 16'h0010};
        rs_val   = 32'd9;
        rt_val   = 32'd1;
        rst_n    = 1'b0;
        @(negedge clk);
        check({br_taken, br_target, wb_data, wb_dest, wb_en} == '0, "R8", "reset mid-run",
              {br_taken, br_target, wb_data, wb_dest, wb_en}, '0);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        drive(1, OPC, 5'd3, 5'd4, 16'h0001, 32'd7, 32'd2, 32'hC000, "R8 after reset R3");
        drive(0, OPC, 5'd0, 5'd0, 16'h0000, 32'd0, 32'd0, 32'd0, "R2 final idle");
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule